// File: doc/BRIEF.md
# Rotate, Bit-Test and Bit-Scan Unit

This block is the bit-manipulation slice of a small processor datapath. Each request carries an operation code, a 16-bit operand, a 5-bit count that doubles as a bit index, the current carry and zero flags, and the current destination value. The block produces a new result word, a new carry flag and a new zero flag. The work is combinational. The outputs are captured in one register stage and held there until the next request.

There are four rotates: left and right, each in a plain form and a through-carry form. In the through-carry form the carry is a seventeenth bit of the rotated value. Four bit-test forms copy one selected bit into carry and then leave that bit alone, force it to 1, force it to 0, or invert it. Two scans return the position of the lowest or the highest set bit. An empty operand sets the zero flag and leaves the destination untouched.

A request is a one-cycle `start` strobe. The captured outputs are valid on the next cycle, and `done` is high for exactly that one cycle.

Top module: `bitmanip_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result`, `carry_out`, `zero_out` and `done` go to 0.
- R2: `done` is high in exactly the cycle after a cycle in which `start` was high, and low otherwise. While `start` is low, `result`, `carry_out` and `zero_out` keep their values, whatever the other inputs do.
- R3: Plain rotate. Code 0 rotates left and code 1 rotates right. The bits leaving one end enter at the other end, so only the count modulo 16 moves bits. For a nonzero count, `carry_out` is the last bit moved: `result[0]` after a left rotate, `result[15]` after a right rotate. A count of 16 therefore leaves the word as it was but still updates carry.
- R4: A rotate of any kind (codes 0 to 3) with a count of 0 returns the operand unchanged, and `carry_out` equals `carry_in`.
- R5: Rotate through carry. Code 2 rotates left and code 3 rotates right. The 17-bit value {carry_in, operand} is rotated by the count. The low 16 bits of the rotated value give `result` and its top bit gives `carry_out`. For example, a left rotate of 0x4020 by 5 with carry 1 yields 0x0414 with carry 0.
- R6: Bit test. The index is the count modulo 16, and `carry_out` gets the operand bit at that index. Code 4 returns the operand unchanged. Code 5 returns it with that bit set, code 6 with that bit cleared, and code 7 with that bit inverted.
- R7: Scan. Code 8 returns the index of the lowest set bit of a nonzero operand. Code 9 returns the index of the highest set bit. The index is zero-extended to 16 bits and `zero_out` is 0.
- R8: A scan (code 8 or 9) of a zero operand returns `dest_in` as `result` and sets `zero_out` to 1.
- R9: Rotates and bit tests pass `zero_in` to `zero_out`. Scans pass `carry_in` to `carry_out`.
- R10: Codes 10 to 15 are reserved. They return the operand unchanged, with `carry_out` = `carry_in` and `zero_out` = `zero_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| op | input | 4 | Operation code (see R3 to R10) |
| operand | input | 16 | Word to rotate, test or scan |
| count | input | 5 | Rotate count, or bit index in its low 4 bits |
| dest_in | input | 16 | Current destination value, kept by an empty scan |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| result | output | 16 | Registered result word |
| carry_out | output | 1 | Registered new carry flag |
| zero_out | output | 1 | Registered new zero flag |
| done | output | 1 | High for one cycle when the outputs are new |

## Verification
The bench applies every count from 0 to 31 to all four rotates, with both carry values, over a set of operands. This covers count 0, count 16 and the counts from 17 upward. A design that reduced the count modulo 16 for the through-carry rotates, or that took carry from the wrong end, would produce wrong carries at those counts. A design that updated carry on a zero count would fail the zero-count vectors. Bit tests run over all 32 index values, so an index that is not wrapped to 16 shows up as a wrong carry. A variant that modified the bit before sampling it also produces a wrong carry. The scans cover every single-bit pattern, every two-bit pattern and the empty word. A wrong search direction, an off-by-one index, or a destination overwritten on an empty scan is caught there. After every request the bench checks one more idle cycle with the inputs scrambled, to confirm that `done` drops and the outputs hold.

// File: rtl/bmu_pkg.sv
// Package: shared operation codes and flag type for the bit-manipulation unit.
// Assumes a 4-bit operation field. Codes 10..15 are reserved and treated as pass-through.
package bmu_pkg;

    typedef enum logic [3:0] {
        OP_ROL      = 4'd0,
        OP_ROR      = 4'd1,
        OP_RCL      = 4'd2,
        OP_RCR      = 4'd3,
        OP_BT       = 4'd4,
        OP_BTS      = 4'd5,
        OP_BTR      = 4'd6,
        OP_BTC      = 4'd7,
        OP_SCAN_FWD = 4'd8,
        OP_SCAN_REV = 4'd9
    } bmu_op_e;

    typedef struct packed {
        logic cf;
        logic zf;
    } bmu_flags_t;

endpackage

// File: rtl/bmu_rotator.sv
// Module: rotator for plain and through-carry rotates, left and right.
// Assumes cnt is already reduced modulo 2**CNT_W by its width.
// Plain rotates use cnt mod W. Through-carry rotates use cnt mod (W+1).
// A zero count leaves both the word and the carry unchanged.
module bmu_rotator #(
    parameter int W     = 16,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     x,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cin,
    input  logic             thru,
    input  logic             right,
    output logic [W-1:0]     res,
    output logic             cout
);

    localparam int WC = W + 1;

    logic [31:0]   cnt_ext;
    logic [31:0]   amt_p;
    logic [31:0]   amt_t;
    logic [W-1:0]  rol_v;
    logic [W-1:0]  ror_v;
    logic [WC-1:0] wide;
    logic [WC-1:0] rcl_v;
    logic [WC-1:0] rcr_v;

    // Reduce the count to the effective distance for each ring size.
    always_comb begin
        cnt_ext = {{(32-CNT_W){1'b0}}, cnt};
        amt_p   = cnt_ext % W;
        amt_t   = cnt_ext % WC;
    end

    // Rotate the 16-bit ring and the 17-bit ring in both directions.
    always_comb begin
        wide  = {cin, x};
        rol_v = (x << amt_p) | (x >> (W - amt_p));
        ror_v = (x >> amt_p) | (x << (W - amt_p));
        rcl_v = (wide << amt_t) | (wide >> (WC - amt_t));
        rcr_v = (wide >> amt_t) | (wide << (WC - amt_t));
    end

    // Select the variant and form the outgoing carry.
    always_comb begin
        if (thru) begin
            res  = right ? rcr_v[W-1:0] : rcl_v[W-1:0];
            cout = right ? rcr_v[W]     : rcl_v[W];
        end else begin
            res  = right ? ror_v : rol_v;
            if (cnt == '0) begin
                cout = cin;
            end else begin
                cout = right ? ror_v[W-1] : rol_v[0];
            end
        end
    end

    // A rotate only moves bits around, so the number of ones is preserved.
    always_comb begin
        if (!$isunknown({x, cin, cnt, thru, right})) begin
            if (thru) begin
                AST_RCR_ONES_KEPT: assert ($countones({cout, res}) == $countones({cin, x})); // R5
            end else begin
                AST_ROT_ONES_KEPT: assert ($countones(res) == $countones(x)); // R3
            end
        end
    end

endmodule

// File: rtl/bmu_bit_tester.sv
// Module: bit test with optional set, clear or invert of the tested bit.
// Assumes idx is already reduced modulo W by its width.
// mode 0 leaves the word, 1 sets the bit, 2 clears it, 3 inverts it.
// The carry always takes the bit as it was before any change.
module bmu_bit_tester #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     x,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       mode,
    output logic [W-1:0]     res,
    output logic             cout
);

    logic [W-1:0] mask;

    // Decode the index into a one-hot mask and sample the original bit.
    always_comb begin
        mask = '0;
        mask[idx] = 1'b1;
        cout = |(x & mask);
    end

    // Apply the chosen modification to the selected bit only.
    always_comb begin
        case (mode)
            2'd1:    res = x | mask;
            2'd2:    res = x & ~mask;
            2'd3:    res = x ^ mask;
            default: res = x;
        endcase
    end

    // At most the selected bit may differ, and a set or clear must take effect.
    always_comb begin
        if (!$isunknown({x, idx, mode})) begin
            AST_BT_ONE_BIT_TOUCHED: assert ($countones(res ^ x) <= 1); // R6
            if (mode == 2'd1) begin
                AST_BTS_BIT_HIGH: assert (res[idx] == 1'b1); // R6
            end
            if (mode == 2'd2) begin
                AST_BTR_BIT_LOW: assert (res[idx] == 1'b0); // R6
            end
        end
    end

endmodule

// File: rtl/bmu_bit_scanner.sv
// Module: finds the lowest (forward) or highest (reverse) set bit of a word.
// The index is valid only when found is high. An empty word gives found = 0.
module bmu_bit_scanner #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     x,
    input  logic             reverse,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Priority search. The last match written wins, so the loop order sets the direction.
    always_comb begin
        found = |x;
        idx   = '0;
        if (reverse) begin
            for (int i = 0; i < W; i++) begin
                if (x[i]) idx = IDX_W'(i);
            end
        end else begin
            for (int i = W - 1; i >= 0; i--) begin
                if (x[i]) idx = IDX_W'(i);
            end
        end
    end

    // The reported bit is set, and nothing lies beyond it in the search direction.
    always_comb begin
        if (!$isunknown({x, reverse}) && found) begin
            AST_SCAN_HIT_SET: assert (x[idx] == 1'b1); // R7
            if (reverse) begin
                AST_SCAN_REV_TOPMOST: assert (((x >> idx) >> 1) == '0); // R7
            end else begin
                AST_SCAN_FWD_LOWEST: assert ((x << (W - int'(idx))) == '0); // R7
            end
        end
    end

endmodule

// File: rtl/bitmanip_unit.sv
// Module: top of the bit-manipulation unit.
// It decodes the operation, runs the rotator, tester and scanner in parallel,
// and captures the selected result and flags on a start strobe.
// Assumes start is a single-cycle request. done follows one cycle later.
// Reset is synchronous and active low.
module bitmanip_unit #(
    parameter int W     = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       op,
    input  logic [W-1:0]     operand,
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     dest_in,
    input  logic             carry_in,
    input  logic             zero_in,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             zero_out,
    output logic             done
);

    import bmu_pkg::*;

    localparam int IDX_W = $clog2(W);

    bmu_op_e            op_q;
    logic [W-1:0]       rot_res;
    logic               rot_cf;
    logic [W-1:0]       bt_res;
    logic               bt_cf;
    logic               scan_found;
    logic [IDX_W-1:0]   scan_idx;
    logic [W-1:0]       nxt_res;
    bmu_flags_t         nxt_flags;

    assign op_q = bmu_op_e'(op);

    bmu_rotator #(.W(W), .CNT_W(CNT_W)) u_rot (
        .x     (operand),
        .cnt   (count),
        .cin   (carry_in),
        .thru  (op[1]),
        .right (op[0]),
        .res   (rot_res),
        .cout  (rot_cf)
    );

    bmu_bit_tester #(.W(W), .IDX_W(IDX_W)) u_bt (
        .x    (operand),
        .idx  (count[IDX_W-1:0]),
        .mode (op[1:0]),
        .res  (bt_res),
        .cout (bt_cf)
    );

    bmu_bit_scanner #(.W(W), .IDX_W(IDX_W)) u_scan (
        .x       (operand),
        .reverse (op[0]),
        .found   (scan_found),
        .idx     (scan_idx)
    );

    // Pick the unit result and the flag updates for the requested operation.
    always_comb begin
        nxt_res      = operand;
        nxt_flags.cf = carry_in;
        nxt_flags.zf = zero_in;
        case (op_q)
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
                nxt_res      = rot_res;
                nxt_flags.cf = rot_cf;
            end
            OP_BT, OP_BTS, OP_BTR, OP_BTC: begin
                nxt_res      = bt_res;
                nxt_flags.cf = bt_cf;
            end
            OP_SCAN_FWD, OP_SCAN_REV: begin
                nxt_res      = scan_found ? {{(W-IDX_W){1'b0}}, scan_idx} : dest_in;
                nxt_flags.zf = ~scan_found;
            end
            default: begin
                nxt_res = operand;
            end
        endcase
    end

    // Output register: capture on start and hold otherwise. done echoes start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            zero_out  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result    <= nxt_res;
                carry_out <= nxt_flags.cf;
                zero_out  <= nxt_flags.zf;
            end
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R2
    AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R2
    AST_OUTPUTS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(carry_out) && $stable(zero_out))); // R2
    AST_EMPTY_SCAN_ZF: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 4'd8 || op == 4'd9) && operand == '0) |=> (zero_out && result == $past(dest_in))); // R8
    AST_SCAN_KEEPS_CF: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 4'd8 || op == 4'd9)) |=> (carry_out == $past(carry_in))); // R9

endmodule

// File: tb/test_bitmanip_unit.sv
`timescale 1ns/1ps
// Bench: sweeps the counts, indices and bit patterns of the unit and compares
// every response with an arithmetic reference built in the bench.
module test_bitmanip_unit;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  op;
    logic [15:0] operand;
    logic [4:0]  count;
    logic [15:0] dest_in;
    logic        carry_in;
    logic        zero_in;
    logic [15:0] result;
    logic        carry_out;
    logic        zero_out;
    logic        done;

    int n_vec = 0;
    int n_bad = 0;

    always #(HALF) clk = ~clk;

    bitmanip_unit i_bitmanip_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .count(count), .dest_in(dest_in), .carry_in(carry_in), .zero_in(zero_in),
        .result(result), .carry_out(carry_out), .zero_out(zero_out), .done(done)
    );

    // Reference: rotates step one bit at a time, the other codes are computed arithmetically.
    task automatic ref_model(input int code, input logic [15:0] x, input int cnt,
                             input logic cin, input logic zin, input logic [15:0] dst,
                             output logic [15:0] r, output logic c, output logic z);
        logic [15:0] v;
        logic        cf;
        logic        t;
        int          k;
        v = x; cf = cin; z = zin;
        case (code)
            0: for (int s = 0; s < cnt; s++) begin cf = v[15]; v = {v[14:0], v[15]}; end
            1: for (int s = 0; s < cnt; s++) begin cf = v[0];  v = {v[0], v[15:1]}; end
            2: for (int s = 0; s < cnt; s++) begin t = v[15]; v = {v[14:0], cf}; cf = t; end
            3: for (int s = 0; s < cnt; s++) begin t = v[0];  v = {cf, v[15:1]}; cf = t; end
            4, 5, 6, 7: begin
                k  = cnt % 16;
                cf = x[k];
                if (code == 5) v[k] = 1'b1;
                if (code == 6) v[k] = 1'b0;
                if (code == 7) v[k] = ~x[k];
            end
            8, 9: begin
                if (x == 16'h0) begin
                    v = dst; z = 1'b1;
                end else begin
                    z = 1'b0;
                    if (code == 8) v = 16'($clog2(int'(x & (~x + 16'h1))));
                    else           v = 16'($clog2(int'(x) + 1) - 1);
                end
            end
            default: ;
        endcase
        r = v; c = cf;
    endtask

    // One request: drive, sample the response, then check one idle cycle with scrambled inputs.
    task automatic apply(input int code, input logic [15:0] x, input int cnt,
                         input logic cin, input logic zin, input logic [15:0] dst,
                         input string tag);
        logic [15:0] er;
        logic        ec;
        logic        ez;
        logic [15:0] held;
        ref_model(code, x, cnt, cin, zin, dst, er, ec, ez);
        @(negedge clk);
        op = code[3:0]; operand = x; count = cnt[4:0];
        carry_in = cin; zero_in = zin; dest_in = dst; start = 1'b1;
        @(negedge clk);
        start = 1'b0; operand = ~x; count = ~cnt[4:0]; carry_in = ~cin;
        zero_in = ~zin; dest_in = ~dst; op = 4'd2;
        n_vec++;
        if (done !== 1'b1 || result !== er || carry_out !== ec || zero_out !== ez) begin
            n_bad++;
            $display("FAIL %s op=%0d x=%h cnt=%0d cin=%b: got res=%h cf=%b zf=%b done=%b, expected res=%h cf=%b zf=%b done=1",
                     tag, code, x, cnt, cin, result, carry_out, zero_out, done, er, ec, ez);
        end
        held = result;
        @(negedge clk);
        n_vec++;
        if (done !== 1'b0 || result !== held || carry_out !== ec || zero_out !== ez) begin
            n_bad++;
            $display("FAIL R2 idle hold: got res=%h cf=%b zf=%b done=%b, expected res=%h cf=%b zf=%b done=0",
                     result, carry_out, zero_out, done, held, ec, ez);
        end
    endtask

    logic [15:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h4020,
                              16'h1234, 16'hABCD, 16'h0100, 16'h7FFE};

    initial begin
        rst_n = 1'b0; start = 1'b0; op = 4'd0; operand = 16'h0; count = 5'd0;
        dest_in = 16'h0; carry_in = 1'b0; zero_in = 1'b0;
        // Raise the outputs before reset so that the reset check below means something.
        @(negedge clk); rst_n = 1'b1; op = 4'd15; operand = 16'hFFFF;
        carry_in = 1'b1; zero_in = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        n_vec++;
        if (result !== 16'h0 || carry_out !== 1'b0 || zero_out !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got res=%h cf=%b zf=%b done=%b, expected 0000 0 0 0",
                     result, carry_out, zero_out, done);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R5 worked example: left through carry, 0x4020 by 5 with carry 1.
        apply(2, 16'h4020, 5, 1'b1, 1'b0, 16'h0, "R5 example");

        // Rotates: every count, both carries, all patterns. Count 0 is tagged R4, count 16 R3.
        for (int code = 0; code < 4; code++)
            for (int c = 0; c < 32; c++)
                for (int ci = 0; ci < 2; ci++)
                    for (int p = 0; p < 8; p++)
                        apply(code, pats[p], c, ci[0], c[0], 16'h0,
                              (c == 0) ? "R4" : (code < 2 ? "R3" : "R5"));

        // Bit tests: every index including the wrapped range 16..31.
        for (int code = 4; code < 8; code++)
            for (int c = 0; c < 32; c++)
                for (int p = 0; p < 8; p++)
                    apply(code, pats[p], c, p[0], c[1], 16'h0, "R6");

        // Scans: every single-bit and two-bit pattern, then mixed words.
        for (int code = 8; code < 10; code++) begin
            for (int i = 0; i < 16; i++)
                apply(code, 16'h1 << i, 0, i[0], 1'b1, 16'h5A5A, "R7");
            for (int i = 0; i < 16; i++)
                for (int j = i + 1; j < 16; j++)
                    apply(code, (16'h1 << i) | (16'h1 << j), 0, 1'b1, 1'b1, 16'hBEEF, "R7");
            for (int p = 1; p < 8; p++)
                apply(code, pats[p], 0, 1'b0, 1'b1, 16'hBEEF, "R7");
            apply(code, 16'h0, 0, 1'b1, 1'b0, 16'hBEEF, "R8");
            apply(code, 16'h0, 0, 1'b0, 1'b0, 16'h1357, "R8");
        end

        // Flag pass-through checks (R9) on a rotate and a bit test with zero_in high.
        apply(0, 16'h1234, 3, 1'b0, 1'b1, 16'h0, "R9");
        apply(5, 16'h0000, 7, 1'b1, 1'b1, 16'h0, "R9");

        // Reserved codes.
        for (int code = 10; code < 16; code++)
            for (int p = 0; p < 3; p++)
                apply(code, pats[p + 3], code, p[0], p[1], 16'hCAFE, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(HALF * 2 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule